// File: doc/BRIEF.md
# Configurable Output Macrocell Bank

This block is a bank of output cells for a programmable sum-of-products logic array. Each cell takes one OR-sum from the array and produces a pin drive value, a pin drive enable and a feedback bit that returns to the array. Two configuration bits per cell choose between a clocked path through a D flip-flop and a direct combinational path, and between active-high and active-low pin polarity. Polarity is applied after the storage element, so the stored state and the pin level may differ.

All cells share a clock, a power-up reset, one asynchronous clear term and one synchronous set term from the array. A test load path lets the flip-flops capture the level seen on their pins, which puts a state machine built from the array straight into any state. A lock input disables that path. Each bidirectional pin is modelled as three separate signals: the level seen at the pad, the value driven and the drive enable.

Top module: `omc_bank`

## Requirements
- R1: Cell i reads its configuration from `cfg_i[2i+1:2i]`. Bit 2i selects polarity (1 = active high, pin equals the selected value; 0 = active low, pin is its inverse). Bit 2i+1 selects the path (0 = flip-flop, 1 = combinational). An all-zero configuration gives a clocked, active-low cell.
- R2: In clocked mode the flip-flop captures the array sum on the rising clock edge when no clear, set or test load applies. The pin shows the stored value through the selected polarity.
- R3: In combinational mode the pin follows the array sum in the same cycle, through the selected polarity.
- R4: The feedback output equals the flip-flop state in clocked mode and equals the pad level in combinational mode.
- R5: `pin_oe_o[i]` equals `oe_term_i[i]` in every mode. With the enable low, the pad level still reaches the feedback of a combinational cell, so the pin acts as a dedicated input.
- R6: While `ar_term_i` is high, every flip-flop is 0 at once, without waiting for a clock edge. The clear wins over the set term and over the test load.
- R7: When `sp_term_i` is high and no clear or test load applies, every flip-flop becomes 1 on the next rising edge. A cleared flip-flop drives an active-low pin high, and a set flip-flop drives it low.
- R8: While `rst_n` is low, all flip-flops are 0. After `rst_n` rises, the first two rising edges still hold the flip-flops at 0, and the third edge loads them.
- R9: When `preload_en_i` is high and `lock_i` is low, each flip-flop loads its own pad level `pin_in_i[i]` on the rising edge. This load takes priority over the set term and over the array sum.
- R10: When `lock_i` is high, `preload_en_i` has no effect, and the flip-flops load from the set term or the array sum as they would without it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the flip-flops load on the rising edge |
| rst_n | input | 1 | Power-up reset, active low, asserted asynchronously and released synchronously |
| cfg_i | input | 2*NUM_CELLS | Per-cell configuration pairs (polarity, path) |
| sum_i | input | NUM_CELLS | OR-sum from the array for each cell |
| oe_term_i | input | NUM_CELLS | Drive-enable term for each pin |
| ar_term_i | input | 1 | Shared asynchronous clear term, active high |
| sp_term_i | input | 1 | Shared synchronous set term, active high |
| preload_en_i | input | 1 | Test load request: flip-flops capture their pad levels |
| lock_i | input | 1 | Lock bit; when high it blocks the test load |
| pin_in_i | input | NUM_CELLS | Level seen at each pad |
| pin_out_o | output | NUM_CELLS | Value driven onto each pad |
| pin_oe_o | output | NUM_CELLS | Drive enable for each pad |
| fb_o | output | NUM_CELLS | Feedback to the array for each cell |

## Verification
The assertions check on every cycle that the asynchronous clear holds the state at zero, that set, test load, locked test load and plain capture each produce the state they should on the next edge, and that combinational cells pass the sum and the pad level through. The bench alone shows the effect of polarity on clocked cells across all four modes. It also shows the latency of reset release, that the clear acts between clock edges, and the priority order of clear, test load and set when they are applied together. A long sweep rotates every cell through all four configurations under mixed stimulus and compares each output against a reference state that the bench keeps itself.

// File: rtl/omc_pkg.sv
package omc_pkg;

  localparam int CFG_W = 2;

  typedef struct packed {
    logic comb_path;  // 1: bypass the flip-flop
    logic act_high;   // 1: pin equals selected value
  } cell_cfg_t;

  typedef enum logic [1:0] {
    LD_ARRAY   = 2'd0,
    LD_SET     = 2'd1,
    LD_PADLOAD = 2'd2
  } load_src_e;

  function automatic cell_cfg_t unpack_cfg(input logic [CFG_W-1:0] raw);
    cell_cfg_t c;
    c.comb_path = raw[1];
    c.act_high  = raw[0];
    return c;
  endfunction

endpackage

// File: rtl/omc_reset_sync.sv
module omc_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/omc_state_flop.sv
module omc_state_flop
  import omc_pkg::*;
(
  input  logic clk,
  input  logic rst_sync_n,
  input  logic ar_term,
  input  logic sp_term,
  input  logic padload_take,
  input  logic sum,
  input  logic pad_in,
  output logic q
);

  load_src_e src;
  logic      q_next;

  // Priority of the clocked sources: pad load, then set, then array sum.
  always_comb begin
    if (padload_take) begin
      src = LD_PADLOAD;
    end else if (sp_term) begin
      src = LD_SET;
    end else begin
      src = LD_ARRAY;
    end
  end

  always_comb begin
    case (src)
      LD_PADLOAD: q_next = pad_in;
      LD_SET:     q_next = 1'b1;
      default:    q_next = sum;
    endcase
  end

  // The clear term is asynchronous and outranks every clocked source.
  always_ff @(posedge clk or negedge rst_sync_n or posedge ar_term) begin
    if (!rst_sync_n) begin
      q <= 1'b0;
    end else if (ar_term) begin
      q <= 1'b0;
    end else begin
      q <= q_next;
    end
  end

  AST_CLEAR_HOLDS_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ar_term |-> (q == 1'b0)); // R6

  AST_SET_LOADS_ONE: assert property (@(posedge clk) disable iff (!rst_sync_n || ar_term)
    (sp_term && !padload_take) |=> (q == 1'b1)); // R7

  AST_PADLOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_sync_n || ar_term)
    padload_take |=> (q == $past(pad_in))); // R9

  AST_ARRAY_CAPTURE: assert property (@(posedge clk) disable iff (!rst_sync_n || ar_term)
    (!padload_take && !sp_term) |=> (q == $past(sum))); // R2

endmodule

// File: rtl/omc_output_stage.sv
module omc_output_stage
  import omc_pkg::*;
(
  input  cell_cfg_t cfg,
  input  logic      sum,
  input  logic      q,
  input  logic      pad_in,
  output logic      pin_out,
  output logic      fb
);

  logic picked;

  always_comb begin
    picked  = cfg.comb_path ? sum : q;
    pin_out = cfg.act_high ? picked : ~picked;
    fb      = cfg.comb_path ? pad_in : q;
  end

endmodule

// File: rtl/omc_bank.sv
module omc_bank
  import omc_pkg::*;
#(
  parameter int NUM_CELLS   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [CFG_W*NUM_CELLS-1:0] cfg_i,
  input  logic [NUM_CELLS-1:0]       sum_i,
  input  logic [NUM_CELLS-1:0]       oe_term_i,
  input  logic                       ar_term_i,
  input  logic                       sp_term_i,
  input  logic                       preload_en_i,
  input  logic                       lock_i,
  input  logic [NUM_CELLS-1:0]       pin_in_i,
  output logic [NUM_CELLS-1:0]       pin_out_o,
  output logic [NUM_CELLS-1:0]       pin_oe_o,
  output logic [NUM_CELLS-1:0]       fb_o
);

  logic                 rst_sync_n;
  logic                 padload_take;
  logic [NUM_CELLS-1:0] state_q;

  omc_reset_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign padload_take = preload_en_i & ~lock_i;

  AST_LOCK_BLOCKS_PADLOAD: assert property (@(posedge clk) disable iff (!rst_sync_n || ar_term_i)
    (lock_i && preload_en_i && !sp_term_i) |=> (state_q == $past(sum_i))); // R10

  for (genvar gi = 0; gi < NUM_CELLS; gi++) begin : g_cell
    cell_cfg_t cell_cfg;

    assign cell_cfg = unpack_cfg(cfg_i[CFG_W*gi +: CFG_W]);

    omc_state_flop u_flop (
      .clk          (clk),
      .rst_sync_n   (rst_sync_n),
      .ar_term      (ar_term_i),
      .sp_term      (sp_term_i),
      .padload_take (padload_take),
      .sum          (sum_i[gi]),
      .pad_in       (pin_in_i[gi]),
      .q            (state_q[gi])
    );

    omc_output_stage u_out (
      .cfg     (cell_cfg),
      .sum     (sum_i[gi]),
      .q       (state_q[gi]),
      .pad_in  (pin_in_i[gi]),
      .pin_out (pin_out_o[gi]),
      .fb      (fb_o[gi])
    );

    assign pin_oe_o[gi] = oe_term_i[gi];

    AST_COMB_PIN_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_i[CFG_W*gi+1] |-> (pin_out_o[gi] == (sum_i[gi] ~^ cfg_i[CFG_W*gi]))); // R3

    AST_COMB_FB_IS_PAD: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_i[CFG_W*gi+1] |-> (fb_o[gi] == pin_in_i[gi])); // R4
  end

endmodule

// File: tb/omc_bank_bench.sv
module omc_bank_bench;

  localparam int  N          = 4;
  localparam time CLK_PERIOD = 10ns;
  localparam int  SWEEP      = 1024;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [2*N-1:0] cfg;
  logic [N-1:0]   sum, oe, pin_in;
  logic           ar, sp, pl, lock;
  logic [N-1:0]   pin_out, pin_oe, fb;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [N-1:0] mq;  // reference state of the flip-flops

  always #(CLK_PERIOD/2) clk = ~clk;

  omc_bank #(.NUM_CELLS(N), .SYNC_STAGES(2)) u_omc_bank (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_i        (cfg),
    .sum_i        (sum),
    .oe_term_i    (oe),
    .ar_term_i    (ar),
    .sp_term_i    (sp),
    .preload_en_i (pl),
    .lock_i       (lock),
    .pin_in_i     (pin_in),
    .pin_out_o    (pin_out),
    .pin_oe_o     (pin_oe),
    .fb_o         (fb)
  );

  task automatic chk(input logic [N-1:0] act, input logic [N-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // Expected pins and feedback from the bench's own state and configuration.
  function automatic logic [N-1:0] exp_pin(input logic [N-1:0] st);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) begin
      logic v;
      v    = cfg[2*i+1] ? sum[i] : st[i];
      r[i] = cfg[2*i] ? v : ~v;
    end
    return r;
  endfunction

  function automatic logic [N-1:0] exp_fb(input logic [N-1:0] st);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) r[i] = cfg[2*i+1] ? pin_in[i] : st[i];
    return r;
  endfunction

  function automatic logic [N-1:0] next_state();
    if (ar) return '0;
    if (pl && !lock) return pin_in;
    if (sp) return '1;
    return sum;
  endfunction

  initial begin
    rst_n = 1'b0; cfg = '0; sum = '1; oe = '0; pin_in = '0;
    ar = 1'b0; sp = 1'b1; pl = 1'b0; lock = 1'b0;

    // R8: state held at zero while reset is low, even with set high.
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk(pin_out, '1, "R1 default config is clocked active-low, zero state drives pins high");
    chk(pin_out, '1, "R8 state zero under reset");
    cfg = {N{2'b01}};  // clocked, active high
    #1 chk(pin_out, '0, "R8 active-high view of zero state under reset");
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk); #1;
    chk(pin_out, '0, "R8 first edge after release still held");
    @(posedge clk); @(negedge clk); #1;
    chk(pin_out, '0, "R8 second edge after release still held");
    @(posedge clk); @(negedge clk); #1;
    chk(pin_out, '1, "R8 third edge loads, R7 set gives one");

    // R7: set flip-flop on an active-low pin drives it low.
    cfg = {N{2'b00}};
    #1 chk(pin_out, '0, "R7 set state on active-low pin reads low");

    // R6: asynchronous clear between edges, and priority over set.
    cfg = {N{2'b01}};
    ar = 1'b1;
    #1 chk(pin_out, '0, "R6 clear acts before any clock edge");
    pl = 1'b1; pin_in = 4'b1011;
    @(posedge clk); @(negedge clk); #1;
    chk(pin_out, '0, "R6 clear outranks set and test load at the edge");
    ar = 1'b0;

    // R9: test load from pads outranks set.
    pin_in = 4'b1010;
    @(posedge clk); @(negedge clk); #1;
    chk(pin_out, 4'b1010, "R9 pad level loaded over set");

    // R10: lock blocks the test load.
    lock = 1'b1; sp = 1'b0; sum = 4'b0011; pin_in = 4'b1100;
    @(posedge clk); @(negedge clk); #1;
    chk(pin_out, 4'b0011, "R10 locked test load ignored, sum captured");
    sp = 1'b1;
    @(posedge clk); @(negedge clk); #1;
    chk(pin_out, 4'b1111, "R10 locked test load ignored, set applies");

    // R5: pin drive enable independent of mode; dedicated input use.
    cfg = {N{2'b10}}; oe = '0; pin_in = 4'b0110;
    #1 chk(pin_oe, '0, "R5 drive off");
    chk(fb, 4'b0110, "R5 pad reaches feedback with drive off");
    oe = 4'b1001;
    #1 chk(pin_oe, 4'b1001, "R5 drive enable follows term");

    // Sweep: every cell cycles through all four modes under mixed stimulus.
    mq = '1;
    pl = 1'b0; lock = 1'b0; sp = 1'b0; ar = 1'b0;
    for (int it = 0; it < SWEEP; it++) begin
      logic [31:0] h;
      h = (it + 1) * 32'h9E3779B1;
      h = h ^ (h >> 13);
      @(negedge clk);
      for (int c = 0; c < N; c++) cfg[2*c +: 2] = 2'((c + (it >> 6)) % 4);
      sum    = h[3:0];
      pin_in = h[7:4];
      oe     = h[11:8];
      ar     = (h[15:12] == 4'd0);
      sp     = (h[18:16] == 3'd0);
      pl     = (h[21:19] == 3'd0);
      lock   = h[24];
      if (ar) mq = '0;
      #1;
      for (int c = 0; c < N; c++) begin
        logic [N-1:0] ep, ef;
        ep = exp_pin(mq);
        ef = exp_fb(mq);
        if (cfg[2*c+1]) begin
          chk(N'(pin_out[c]), N'(ep[c]), "R3 combinational pin");
        end else begin
          chk(N'(pin_out[c]), N'(ep[c]), "R2 clocked pin");
        end
        chk(N'(fb[c]), N'(ef[c]), "R4 feedback source");
      end
      chk(pin_oe, oe, "R5 drive enable");
      begin
        logic [N-1:0] nx;
        nx = next_state();
        @(posedge clk);
        mq = nx;
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule